// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block moves a small microcontroller-class chip between its running state and one of four sleep levels. Software picks a level on `sleepMode` and pulses `sleepReq`. The controller then halts the CPU, and for the deeper levels it also steps through peripheral reset and core power removal. Each step waits for an acknowledge on `stepAck`, which stands in for power-good and settle signals from the analog side. Wake-up runs the same steps in reverse.

Each level accepts its own set of wake sources: an interrupt summary line, a sleep-timer compare hit, and external wake pins. The lightest deep level keeps the core powered and holds every peripheral in reset except a parameter-selected group of debug blocks, so breakpoints and trace setup are kept. The block keeps one status record of the level that was left and the source that ended it. Software reads it after the return to run and clears it with `statusClr`.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset the block is in run. `cpuHalt`=0, `coreOn`=1, `periphRst`=0, `timerEn`=1, `ramPwr` is all ones, and `stValid`, `stMode` and `stSrc` are 0.
- R2: Level codes on `sleepMode` are 0 idle, 1 emulated deep, 2 deep with timer, 3 deep without timer. A request with `sleepMode[2]`=1 is ignored, and `cpuHalt` stays 0 on the following cycle.
- R3: In idle, only `cpuHalt` is raised. `irqAny` returns the block to run on the next edge. Timer hits and wake pins are ignored.
- R4: Deep entry order, with each step taking one `stepAck`:
  - the CPU is halted first;
  - then `periphRst` is asserted;
  - then, for levels 2 and 3, `coreOn` drops.
- R5: At level 2 with the core off:
  - `timerEn` stays 1;
  - `ramPwr` equals the `ramKeep` value captured at the request, bit per bank;
  - a timer hit or any wake pin wakes the chip;
  - `irqAny` does not.
- R6: At level 3 with the core off:
  - `timerEn` is 0;
  - `ramPwr` follows the captured retention mask as at level 2;
  - only wake pins wake the chip, and a timer hit is ignored.
- R7: At level 1:
  - `coreOn` stays 1 and `ramPwr` stays all ones;
  - `periphRst` asserts every bit except those set in `DBG_KEEP` (default bits 7:4, so 8'h0F);
  - a timer hit or a wake pin wakes the chip;
  - the exit skips the power step.
- R8: Deep exit order, with each step taking one `stepAck`:
  - at levels 2 and 3, `coreOn` and `ramPwr` return first while the resets stay asserted;
  - then `periphRst` releases with `cpuHalt` still 1;
  - then `cpuHalt` falls.
- R9: A wake accepted by the current level during the halt or reset step aborts entry. The block returns to run on the next edge, and `coreOn` never drops.
- R10: On every return to run:
  - `stValid` becomes 1 and `stMode` is the level code;
  - `stSrc` is 1 for an interrupt, 2 for a timer hit, 3 for a pin; when several sources are active, pin wins over timer and timer wins over interrupt;
  - `statusClr` zeroes all three fields, but a status update in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Sleep request strobe, sampled in run |
| sleepMode | input | 3 | Requested level code |
| ramKeep | input | BANKS | Retention selection, one bit per RAM bank |
| irqAny | input | 1 | Any enabled interrupt pending |
| timerHit | input | 1 | Sleep-timer compare match |
| wakePins | input | PINS | External wake pins, active high |
| stepAck | input | 1 | Power-good / step-settled acknowledge |
| statusClr | input | 1 | Clears the exit status record |
| cpuHalt | output | 1 | CPU halt request |
| coreOn | output | 1 | Core domain power enable |
| periphRst | output | PERIPHS | Peripheral resets, active high |
| timerEn | output | 1 | Sleep-timer run enable |
| ramPwr | output | BANKS | Per-bank RAM power enable |
| stValid | output | 1 | Exit status record valid |
| stMode | output | 2 | Level that was exited |
| stSrc | output | 2 | Wake source of the last exit |

## Verification
The bench checks that each level takes only its own wake sources. A controller with the wake sets swapped would leave level 3 on a timer hit, or leave idle on a wake pin. The bench also checks that the emulated level skips the power step and keeps the debug resets low. A design that treated level 1 like level 2 would drop `coreOn` or reset the debug blocks. Abort during entry is tested: the block must reach run without ever cutting core power. Finally, the bench checks status priority, where a design with the source order reversed would report an interrupt instead of a pin.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    S_RUN, S_IDLE, S_HALT, S_RST, S_PWR, S_SLEEP, S_UP, S_REL
  } slp_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // take mode and retention mask
    logic latchSrc;    // hold the wake source seen in sleep
    logic commitLive;  // write status with the current source
    logic commitHeld;  // write status with the held source
  } slp_strobe_t;

  localparam logic [1:0] SRC_IRQ = 2'd1;
  localparam logic [1:0] SRC_TMR = 2'd2;
  localparam logic [1:0] SRC_PIN = 2'd3;
endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int PINS  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  slp_strobe_t      strb,
  input  logic [2:0]       sleepMode,
  input  logic [BANKS-1:0] ramKeep,
  input  logic             irqAny,
  input  logic             timerHit,
  input  logic [PINS-1:0]  wakePins,
  input  logic             statusClr,
  output logic [1:0]       modeQ,
  output logic [BANKS-1:0] keepQ,
  output logic             wakeHit,
  output logic             stValid,
  output logic [1:0]       stMode,
  output logic [1:0]       stSrc
);
  logic [1:0] srcQ, liveSrc;
  logic allowIrq, allowTmr, allowPin;

  always_comb begin
    allowIrq = (modeQ == 2'd0);
    allowTmr = (modeQ == 2'd1) || (modeQ == 2'd2);
    allowPin = (modeQ != 2'd0);
    if (allowPin && (|wakePins))  liveSrc = SRC_PIN;
    else if (allowTmr && timerHit) liveSrc = SRC_TMR;
    else if (allowIrq && irqAny)   liveSrc = SRC_IRQ;
    else                           liveSrc = 2'd0;
    wakeHit = (liveSrc != 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      keepQ   <= '0;
      srcQ    <= '0;
      stValid <= 1'b0;
      stMode  <= '0;
      stSrc   <= '0;
    end else begin
      if (strb.capture) begin
        modeQ <= sleepMode[1:0];
        keepQ <= ramKeep;
      end
      if (strb.latchSrc) srcQ <= liveSrc;
      if (strb.commitLive || strb.commitHeld) begin
        stValid <= 1'b1;
        stMode  <= modeQ;
        stSrc   <= strb.commitLive ? liveSrc : srcQ;
      end else if (statusClr) begin
        stValid <= 1'b0;
        stMode  <= '0;
        stSrc   <= '0;
      end
    end
  end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int                 BANKS    = 4,
  parameter int                 PERIPHS  = 8,
  parameter logic [PERIPHS-1:0] DBG_KEEP = 8'hF0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic [2:0]         sleepMode,
  input  logic               stepAck,
  input  logic               wakeHit,
  input  logic [1:0]         modeQ,
  input  logic [BANKS-1:0]   keepQ,
  output slp_strobe_t        strb,
  output logic               cpuHalt,
  output logic               coreOn,
  output logic [PERIPHS-1:0] periphRst,
  output logic               timerEn,
  output logic [BANKS-1:0]   ramPwr
);
  slp_state_t st, nxt;
  logic offWin, rstWin, emul;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_RUN;
    else       st <= nxt;
  end

  always_comb begin
    nxt  = st;
    strb = '0;
    emul = (modeQ == 2'd1);
    case (st)
      S_RUN: if (sleepReq && !sleepMode[2]) begin
        strb.capture = 1'b1;
        nxt = (sleepMode[1:0] == 2'd0) ? S_IDLE : S_HALT;
      end
      S_IDLE: if (wakeHit) begin
        strb.commitLive = 1'b1;
        nxt = S_RUN;
      end
      S_HALT: if (wakeHit) begin
        strb.commitLive = 1'b1;
        nxt = S_RUN;
      end else if (stepAck) nxt = S_RST;
      S_RST: if (wakeHit) begin
        strb.commitLive = 1'b1;
        nxt = S_RUN;
      end else if (stepAck) nxt = emul ? S_SLEEP : S_PWR;
      S_PWR: if (stepAck) nxt = S_SLEEP;
      S_SLEEP: if (wakeHit) begin
        strb.latchSrc = 1'b1;
        nxt = emul ? S_REL : S_UP;
      end
      S_UP: if (stepAck) nxt = S_REL;
      S_REL: if (stepAck) begin
        strb.commitHeld = 1'b1;
        nxt = S_RUN;
      end
      default: nxt = S_RUN;
    endcase
  end

  always_comb begin
    offWin    = modeQ[1] && ((st == S_PWR) || (st == S_SLEEP));
    rstWin    = (st == S_RST) || (st == S_PWR) || (st == S_SLEEP) || (st == S_UP);
    cpuHalt   = (st != S_RUN);
    coreOn    = !offWin;
    ramPwr    = offWin ? keepQ : '1;
    timerEn   = !(offWin && (modeQ == 2'd3));
    periphRst = rstWin ? ((modeQ == 2'd1) ? ~DBG_KEEP : '1) : '0;
  end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int                 BANKS    = 4,
  parameter int                 PINS     = 2,
  parameter int                 PERIPHS  = 8,
  parameter logic [PERIPHS-1:0] DBG_KEEP = 8'hF0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic [2:0]         sleepMode,
  input  logic [BANKS-1:0]   ramKeep,
  input  logic               irqAny,
  input  logic               timerHit,
  input  logic [PINS-1:0]    wakePins,
  input  logic               stepAck,
  input  logic               statusClr,
  output logic               cpuHalt,
  output logic               coreOn,
  output logic [PERIPHS-1:0] periphRst,
  output logic               timerEn,
  output logic [BANKS-1:0]   ramPwr,
  output logic               stValid,
  output logic [1:0]         stMode,
  output logic [1:0]         stSrc
);
  slp_strobe_t      strb;
  logic [1:0]       modeQ;
  logic [BANKS-1:0] keepQ;
  logic             wakeHit;

  sleep_dp #(.BANKS(BANKS), .PINS(PINS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sleepMode(sleepMode),
    .ramKeep(ramKeep), .irqAny(irqAny), .timerHit(timerHit),
    .wakePins(wakePins), .statusClr(statusClr), .modeQ(modeQ),
    .keepQ(keepQ), .wakeHit(wakeHit), .stValid(stValid),
    .stMode(stMode), .stSrc(stSrc)
  );

  sleep_fsm #(.BANKS(BANKS), .PERIPHS(PERIPHS), .DBG_KEEP(DBG_KEEP)) fsm_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
    .stepAck(stepAck), .wakeHit(wakeHit), .modeQ(modeQ), .keepQ(keepQ),
    .strb(strb), .cpuHalt(cpuHalt), .coreOn(coreOn), .periphRst(periphRst),
    .timerEn(timerEn), .ramPwr(ramPwr)
  );
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int BANKS   = 4,
  parameter int PINS    = 2,
  parameter int PERIPHS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               sleepReq,
  input logic [2:0]         sleepMode,
  input logic               statusClr,
  input logic               cpuHalt,
  input logic               coreOn,
  input logic [PERIPHS-1:0] periphRst,
  input logic               timerEn,
  input logic [BANKS-1:0]   ramPwr,
  input logic               stValid
);
  AST_RST_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (periphRst != '0) |-> cpuHalt); // R4

  AST_CORE_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !coreOn |-> (cpuHalt && (periphRst == '1))); // R4

  AST_TIMER_STOP_CORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |-> !coreOn); // R6

  AST_RAM_GATED_CORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ramPwr != '1) |-> !coreOn); // R5

  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> (coreOn && (periphRst == '0))); // R8

  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && sleepReq && sleepMode[2]) |=> !cpuHalt); // R2

  AST_STATUS_ON_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> stValid); // R10
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.BANKS(BANKS), .PINS(PINS), .PERIPHS(PERIPHS)) chk_i (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
  .statusClr(statusClr), .cpuHalt(cpuHalt), .coreOn(coreOn),
  .periphRst(periphRst), .timerEn(timerEn), .ramPwr(ramPwr), .stValid(stValid)
);

// File: tb/sleep_ctrl_tb_top.sv
module sleep_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 0, irqAny = 0, timerHit = 0, stepAck = 0, statusClr = 0;
  logic [2:0] sleepMode = 0;
  logic [3:0] ramKeep = 0;
  logic [1:0] wakePins = 0;
  logic cpuHalt, coreOn, timerEn, stValid;
  logic [7:0] periphRst;
  logic [3:0] ramPwr;
  logic [1:0] stMode, stSrc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sleep_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
    .ramKeep(ramKeep), .irqAny(irqAny), .timerHit(timerHit),
    .wakePins(wakePins), .stepAck(stepAck), .statusClr(statusClr),
    .cpuHalt(cpuHalt), .coreOn(coreOn), .periphRst(periphRst),
    .timerEn(timerEn), .ramPwr(ramPwr), .stValid(stValid),
    .stMode(stMode), .stSrc(stSrc)
  );

  typedef struct {
    string      tag;
    logic [23:0] val; // {halt,core,rst[7:0],ten,ram[3:0],v,mode[1:0],src[1:0],pad}
  } exp_t;

  exp_t q[$];
  event expEv;

  function automatic logic [23:0] pack(logic h, logic c, logic [7:0] r, logic t,
                                       logic [3:0] m, logic v, logic [1:0] md,
                                       logic [1:0] s);
    return {h, c, r, t, m, v, md, s, 4'b0};
  endfunction

  // driver side: push the expected outputs, then let the monitor compare
  task automatic expect_out(string tag, logic h, logic c, logic [7:0] r, logic t,
                            logic [3:0] m, logic v, logic [1:0] md, logic [1:0] s);
    exp_t e;
    e.tag = tag;
    e.val = pack(h, c, r, t, m, v, md, s);
    q.push_back(e);
    ->expEv;
    #1;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(expEv);
      while (q.size() > 0) begin
        exp_t e;
        logic [23:0] act;
        e = q.pop_front();
        act = pack(cpuHalt, coreOn, periphRst, timerEn, ramPwr, stValid, stMode, stSrc);
        checks++;
        if (act !== e.val) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ack();
    stepAck = 1; tick(); stepAck = 0;
  endtask

  task automatic req(logic [2:0] m);
    sleepMode = m; sleepReq = 1; tick(); sleepReq = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) tick();
    rstN = 1;
    tick();
    expect_out("R1 reset state", 0, 1, 8'h00, 1, 4'hF, 0, 0, 0);

    // R2: unsupported code ignored
    req(3'd5);
    expect_out("R2 bad mode ignored", 0, 1, 8'h00, 1, 4'hF, 0, 0, 0);

    // R3: idle
    req(3'd0);
    expect_out("R3 idle halts only", 1, 1, 8'h00, 1, 4'hF, 0, 0, 0);
    timerHit = 1; wakePins = 2'b01; tick(); timerHit = 0; wakePins = 0;
    expect_out("R3 idle ignores timer and pins", 1, 1, 8'h00, 1, 4'hF, 0, 0, 0);
    irqAny = 1; tick(); irqAny = 0;
    expect_out("R3 R10 irq wakes idle", 0, 1, 8'h00, 1, 4'hF, 1, 0, 1);
    statusClr = 1; tick(); statusClr = 0;
    expect_out("R10 status cleared", 0, 1, 8'h00, 1, 4'hF, 0, 0, 0);

    // R4 R5 R8: level 2 full cycle
    ramKeep = 4'b0101;
    req(3'd2);
    ramKeep = 4'b1111;
    expect_out("R4 halt first", 1, 1, 8'h00, 1, 4'hF, 0, 0, 0);
    ack();
    expect_out("R4 resets second", 1, 1, 8'hFF, 1, 4'hF, 0, 0, 0);
    ack();
    expect_out("R5 core off, retention mask", 1, 0, 8'hFF, 1, 4'h5, 0, 0, 0);
    ack();
    irqAny = 1; tick(); irqAny = 0;
    expect_out("R5 irq does not wake", 1, 0, 8'hFF, 1, 4'h5, 0, 0, 0);
    timerHit = 1; tick(); timerHit = 0;
    expect_out("R8 power back, resets held", 1, 1, 8'hFF, 1, 4'hF, 0, 0, 0);
    ack();
    expect_out("R8 resets released, halt held", 1, 1, 8'h00, 1, 4'hF, 0, 0, 0);
    ack();
    expect_out("R8 R10 back in run, timer src", 0, 1, 8'h00, 1, 4'hF, 1, 2, 2);

    // R6: level 3
    ramKeep = 4'b0011;
    req(3'd3);
    ack(); ack(); ack();
    expect_out("R6 timer stopped", 1, 0, 8'hFF, 0, 4'h3, 1, 2, 2);
    timerHit = 1; tick(); timerHit = 0;
    expect_out("R6 timer hit ignored", 1, 0, 8'hFF, 0, 4'h3, 1, 2, 2);
    wakePins = 2'b10; irqAny = 1; tick(); wakePins = 0; irqAny = 0;
    ack(); ack();
    expect_out("R6 R10 pin wake status", 0, 1, 8'h00, 1, 4'hF, 1, 3, 3);

    // R7: emulated level
    req(3'd1);
    ack(); ack();
    expect_out("R7 debug resets kept low", 1, 1, 8'h0F, 1, 4'hF, 1, 3, 3);
    timerHit = 1; wakePins = 2'b01; tick(); timerHit = 0; wakePins = 0;
    expect_out("R7 exit skips power step", 1, 1, 8'h00, 1, 4'hF, 1, 3, 3);
    ack();
    expect_out("R7 R10 pin beats timer", 0, 1, 8'h00, 1, 4'hF, 1, 1, 3);

    // R9: abort in halt step, with a status clear in the same cycle
    req(3'd2);
    timerHit = 1; statusClr = 1; tick(); timerHit = 0; statusClr = 0;
    expect_out("R9 R10 abort in halt, update beats clear", 0, 1, 8'h00, 1, 4'hF, 1, 2, 2);

    // R9: abort in reset step
    req(3'd3);
    ack();
    expect_out("R9 in reset step", 1, 1, 8'hFF, 1, 4'hF, 1, 2, 2);
    timerHit = 1; tick(); timerHit = 0;
    expect_out("R9 timer not accepted at level 3", 1, 1, 8'hFF, 1, 4'hF, 1, 2, 2);
    wakePins = 2'b01; tick(); wakePins = 0;
    expect_out("R9 pin aborts entry", 0, 1, 8'h00, 1, 4'hF, 1, 3, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule